// File: doc/BRIEF.md
# Virtual-Output-Queue Crossbar Scheduler

This block chooses the crossbar connections for one timeslot of an N-by-N switch in which every input keeps a separate queue for each output. Each input supplies N request bits, one per output, so a packet that cannot leave does not hide traffic bound for other outputs. A one-cycle start pulse captures the whole request matrix. The block then runs request-grant-accept rounds, one per clock, until a round adds no new pair or N rounds have been run. It then pulses a done strobe and presents a conflict-free, maximal matching.

Each output keeps a round-robin grant pointer over the inputs, and each input keeps a round-robin accept pointer over the outputs. A pointer moves to one place past its partner only when that pair is formed in the first round of a timeslot. This rule prevents starvation under steady load. The result is shown as an N-by-N grant matrix and also as a per-input valid flag with an output index.

Top module: `voq_xbar_sched`

## Requirements
- R1: When `start_i` is high while the block is idle, `req_i` is captured, with bit `i*N+o` meaning that input i has traffic for output o. Changes on `req_i` after that edge have no effect on the timeslot.
- R2: In the matching, each input is paired with at most one output, and each output is paired with at most one input.
- R3: Every granted pair was requested in the captured matrix. An input whose N request bits are all zero gets no grant.
- R4: At done, no captured request has both its input and its output unpaired. The matching is maximal.
- R5: `done_o` is high for exactly one cycle, c clock edges after the start edge, with 1 <= c <= N. An all-zero request matrix gives c = 1. A single request gives c = 2. After reset `done_o` and all grant outputs are zero.
- R6: `grant_o` uses the same bit layout as `req_i`. `gvalid_o[i]` is high exactly when row i holds a grant, and `gidx_o[i*IDXW +: IDXW]` then gives its output number. These values stay unchanged from done until the next accepted start.
- R7: Both pointer sets reset to zero. An output grants the unpaired requesting input that is nearest at or after its pointer, in ascending order with wrap-around. An input accepts the granted output that is nearest at or after its pointer. Pointers move to one past the partner, modulo N, only for pairs formed in round one. With N = 4 and all 16 requests set, the first timeslot after reset pairs input k with output k after 4 cycles. The second such timeslot pairs 0-1, 1-0, 2-2 and 3-3, also after 4 cycles.
- R8: A start pulse that arrives while rounds are still running is ignored. It produces no extra done and does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a timeslot and captures the requests |
| req_i | input | N*N | Request matrix, bit i*N+o = input i has traffic for output o |
| done_o | output | 1 | One-cycle pulse when the matching is final |
| grant_o | output | N*N | Matching, same layout as req_i |
| gvalid_o | output | N | Input i holds a grant |
| gidx_o | output | N*IDXW | Output index granted to each input |

## Verification
Each round takes one clock and is registered, so the done pulse and the final matching appear at the same edge. That edge is c edges after the start edge, where c is the number of rounds used. The scoreboard monitor samples one time unit after each rising edge, counts edges from the captured start, and compares c with the value each stimulus predicts: exactly 1 for no requests, 2 for a single request, 4 for the full matrices, and at most N for random matrices. The grant checks run in the cycle of the done pulse. In the idle cycles that follow, the monitor checks that the grants do not change while `req_i` is driven with unrelated values.

// File: rtl/voq_sched_pkg.sv
package voq_sched_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sched_state_e;

  // position one past the set bit of a one-hot vector, wrapped at n
  function automatic int unsigned rr_next(input logic [31:0] onehot, input int unsigned n);
    int unsigned pos;
    pos = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (onehot[k]) pos = k;
    end
    return ((pos + 1) >= n) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/voq_rr_pick.sv
module voq_rr_pick #(
  parameter int N = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    cand_i,
  input  logic [IDXW-1:0] ptr_i,
  output logic [N-1:0]    pick_o
);

  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int k = 0; k < N; k++) begin
      int pos;
      pos = int'(ptr_i) + k;
      if (pos >= N) pos = pos - N;
      if (!found && cand_i[pos]) begin
        pick_o[pos] = 1'b1;
        found       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/voq_rga_round.sv
module voq_rga_round #(
  parameter int N = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][N-1:0]    req_i,
  input  logic [N-1:0]           in_free_i,
  input  logic [N-1:0]           out_free_i,
  input  logic [N-1:0][IDXW-1:0] gptr_i,
  input  logic [N-1:0][IDXW-1:0] aptr_i,
  output logic [N-1:0][N-1:0]    acc_o
);

  logic [N-1:0][N-1:0] elig_m;   // [input][output]
  logic [N-1:0][N-1:0] elig_t;   // [output][input]
  logic [N-1:0][N-1:0] gsel_t;   // [output][input]
  logic [N-1:0][N-1:0] gnt_m;    // [input][output]

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar o = 0; o < N; o++) begin : g_col
      assign elig_m[i][o] = req_i[i][o] & in_free_i[i] & out_free_i[o];
      assign elig_t[o][i] = elig_m[i][o];
      assign gnt_m[i][o]  = gsel_t[o][i];
    end
  end

  // grant step: one picker per output over requesting inputs
  for (genvar o = 0; o < N; o++) begin : g_grant
    voq_rr_pick #(.N(N)) u_gpick (
      .cand_i (elig_t[o]),
      .ptr_i  (gptr_i[o]),
      .pick_o (gsel_t[o])
    );
  end

  // accept step: one picker per input over granting outputs
  for (genvar i = 0; i < N; i++) begin : g_accept
    voq_rr_pick #(.N(N)) u_apick (
      .cand_i (gnt_m[i]),
      .ptr_i  (aptr_i[i]),
      .pick_o (acc_o[i])
    );
  end

endmodule

// File: rtl/voq_grant_encode.sv
module voq_grant_encode #(
  parameter int N = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][N-1:0] match_i,
  output logic [N-1:0]        gvalid_o,
  output logic [N*IDXW-1:0]   gidx_o
);

  for (genvar i = 0; i < N; i++) begin : g_enc
    logic [IDXW-1:0] idx;
    always_comb begin
      idx = '0;
      for (int o = 0; o < N; o++) begin
        if (match_i[i][o]) idx = idx | IDXW'(o);
      end
    end
    assign gvalid_o[i]               = |match_i[i];
    assign gidx_o[i*IDXW +: IDXW]    = idx;
  end

endmodule

// File: rtl/voq_xbar_sched.sv
module voq_xbar_sched
  import voq_sched_pkg::*;
#(
  parameter int N = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [N*N-1:0]    req_i,
  output logic              done_o,
  output logic [N*N-1:0]    grant_o,
  output logic [N-1:0]      gvalid_o,
  output logic [N*IDXW-1:0] gidx_o
);

  localparam logic [IDXW-1:0] LAST_ROUND = IDXW'(N - 1);

  sched_state_e state_q, state_d;
  logic [IDXW-1:0] round_q, round_d;
  logic [N-1:0][N-1:0] req_q;
  logic [N-1:0][N-1:0] match_q, match_d;
  logic [N-1:0][IDXW-1:0] gptr_q, gptr_d;
  logic [N-1:0][IDXW-1:0] aptr_q, aptr_d;
  logic done_q, done_d;

  logic [N-1:0][N-1:0] col_m;   // [output][input] view of match_q
  logic [N-1:0][N-1:0] acc_m;   // new pairs of this round [input][output]
  logic [N-1:0][N-1:0] acc_t;   // [output][input]
  logic [N-1:0] in_free, out_free;
  logic load_en, run_en, ptr_en, any_new;

  for (genvar i = 0; i < N; i++) begin : g_tr
    for (genvar o = 0; o < N; o++) begin : g_tc
      assign col_m[o][i] = match_q[i][o];
      assign acc_t[o][i] = acc_m[i][o];
    end
    assign in_free[i]  = ~|match_q[i];
    assign out_free[i] = ~|col_m[i];
  end

  voq_rga_round #(.N(N)) u_round (
    .req_i      (req_q),
    .in_free_i  (in_free),
    .out_free_i (out_free),
    .gptr_i     (gptr_q),
    .aptr_i     (aptr_q),
    .acc_o      (acc_m)
  );

  assign load_en = (state_q == ST_IDLE) && start_i;
  assign run_en  = (state_q == ST_RUN);
  assign ptr_en  = run_en && (round_q == '0);
  assign any_new = |acc_m;

  // next state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    round_d = round_q + 1'b1;
    match_d = match_q | acc_m;
    if (load_en) begin
      state_d = ST_RUN;
      round_d = '0;
      match_d = '0;
    end else if (run_en) begin
      if (!any_new || (round_q == LAST_ROUND)) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  // pointer moves, used only in the first round
  always_comb begin
    gptr_d = gptr_q;
    aptr_d = aptr_q;
    for (int o = 0; o < N; o++) begin
      if (|acc_t[o]) gptr_d[o] = IDXW'(rr_next(32'(acc_t[o]), N));
    end
    for (int i = 0; i < N; i++) begin
      if (|acc_m[i]) aptr_d[i] = IDXW'(rr_next(32'(acc_m[i]), N));
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      round_q <= '0;
      req_q   <= '0;
      match_q <= '0;
      gptr_q  <= '0;
      aptr_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load_en) req_q <= req_i;
      if (load_en || run_en) begin
        match_q <= match_d;
        round_q <= round_d;
      end
      if (ptr_en) begin
        gptr_q <= gptr_d;
        aptr_q <= aptr_d;
      end
    end
  end

  voq_grant_encode #(.N(N)) u_enc (
    .match_i  (match_q),
    .gvalid_o (gvalid_o),
    .gidx_o   (gidx_o)
  );

  assign done_o  = done_q;
  assign grant_o = match_q;

  // ---------------- assertions ----------------
  logic [N-1:0][N-1:0] open_pair;
  logic [N*N-1:0] stray_flat;
  always_comb begin
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++)
        open_pair[i][o] = req_q[i][o] & in_free[i] & out_free[o];
  end
  assign stray_flat = match_q & ~req_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_row_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_q[k]));
    assert_col_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_m[k]));
  end

  assert_grant_in_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> (stray_flat == '0));

  assert_maximal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (open_pair == '0));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_req_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(req_q));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !start_i) |=> $stable(match_q));

  assert_ptr_late_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (round_q != '0)) |=> ($stable(gptr_q) && $stable(aptr_q)));

endmodule

// File: tb/voq_xbar_sched_test.sv
module voq_xbar_sched_test;

  localparam int N     = 4;
  localparam int IDXW  = 2;
  localparam int NN    = N * N;
  localparam int CLK_P = 10;

  logic clk, rst_n, start_i, done_o;
  logic [NN-1:0] req_i, grant_o;
  logic [N-1:0] gvalid_o;
  logic [N*IDXW-1:0] gidx_o;

  int n_chk, n_fail;

  typedef struct {
    logic [NN-1:0] req;
    int            lat;    // 0: only the bound 1..N
    bit            exact;
    logic [NN-1:0] g;
  } item_t;
  item_t sb[$];

  bit active, have_last;
  int cnt;
  logic [NN-1:0] last_g;

  voq_xbar_sched #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
    .done_o(done_o), .grant_o(grant_o), .gvalid_o(gvalid_o), .gidx_o(gidx_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic judge(input item_t it, input int c);
    bit ok2, ok4, okv;
    ok2 = 1; ok4 = 1; okv = 1;
    if (it.lat > 0) check(c == it.lat, "R5 latency", c, it.lat);
    else check(c >= 1 && c <= N, "R5 latency bound", c, N);
    check((grant_o & ~it.req) == '0, "R1 R3 grant outside captured requests", grant_o, it.req);
    for (int i = 0; i < N; i++) begin
      int rc, cc;
      rc = 0; cc = 0;
      for (int o = 0; o < N; o++) begin
        rc += grant_o[i*N+o];
        cc += grant_o[o*N+i];
      end
      if (rc > 1 || cc > 1) ok2 = 0;
      if (it.req[i*N +: N] == '0 && gvalid_o[i]) okv = 0;
    end
    check(ok2, "R2 one-to-one", grant_o, 0);
    check(okv, "R3 zero row granted", gvalid_o, 0);
    for (int i = 0; i < N; i++)
      for (int o = 0; o < N; o++) begin
        bit rf, cf;
        rf = (grant_o[i*N +: N] == '0);
        cf = 1;
        for (int k = 0; k < N; k++) if (grant_o[k*N+o]) cf = 0;
        if (it.req[i*N+o] && rf && cf) ok4 = 0;
      end
    check(ok4, "R4 maximal", grant_o, it.req);
    begin
      logic [N-1:0] ev;
      logic [N*IDXW-1:0] ex;
      ev = '0; ex = '0;
      for (int i = 0; i < N; i++)
        for (int o = 0; o < N; o++)
          if (grant_o[i*N+o]) begin
            ev[i] = 1'b1;
            ex[i*IDXW +: IDXW] = IDXW'(o);
          end
      check(gvalid_o == ev, "R6 gvalid", gvalid_o, ev);
      check((gidx_o & ~{N{ {IDXW{1'b0}} }}) == ex || 1'b0 ? 1'b1 : (gidx_o == ex), "R6 gidx", gidx_o, ex);
    end
    if (it.exact) check(grant_o == it.g, "R7 exact matching", grant_o, it.g);
  endtask

  // monitor
  initial begin
    active = 0; have_last = 0; cnt = 0; last_g = '0;
    forever begin
      bit st;
      @(posedge clk);
      st = start_i;
      #1;
      if (!rst_n) continue;
      if (active) begin
        cnt++;
        if (done_o) begin
          item_t it;
          if (sb.size() == 0) check(0, "R8 done without stimulus", 1, 0);
          else begin
            it = sb.pop_front();
            judge(it, cnt);
          end
          active = 0;
          last_g = grant_o;
          have_last = 1;
        end
      end else if (st) begin
        active = 1;
        cnt = 0;
      end else if (done_o) begin
        check(0, "R8 extra done", 1, 0);
      end else if (have_last) begin
        check(grant_o == last_g, "R6 hold after done", grant_o, last_g);
      end
    end
  end

  task automatic slot(input logic [NN-1:0] r, input int lat, input bit ex,
                      input logic [NN-1:0] g, input bit poke);
    item_t it;
    it.req = r; it.lat = lat; it.exact = ex; it.g = g;
    @(negedge clk);
    req_i = r;
    start_i = 1'b1;
    sb.push_back(it);
    @(negedge clk);
    start_i = 1'b0;
    req_i = NN'($urandom);   // R1: changes after capture must not matter
    if (poke) begin
      start_i = 1'b1;        // R8: start while busy
      req_i = '1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (active || sb.size() != 0) @(negedge clk);
    repeat (3) begin
      req_i = NN'($urandom);
      @(negedge clk);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; req_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R5 reset done", done_o, 0);
    check(grant_o == '0, "R5 reset grant", grant_o, 0);
    check(gvalid_o == '0, "R6 reset gvalid", gvalid_o, 0);

    // R7: full matrix from reset pointers gives the identity
    slot('1, N, 1'b1, NN'(16'h8421), 1'b0);
    // R7: second full matrix, pointers moved by first-round pairs only
    slot('1, 4, 1'b1, NN'(16'h8412), 1'b0);
    // R5 R3: no requests
    slot('0, 1, 1'b1, '0, 1'b0);
    // R5 R8: single request (input 2 -> output 1), busy start ignored
    slot(NN'(1) << 9, 2, 1'b1, NN'(1) << 9, 1'b1);
    // all inputs want output 3 only: one pair, then an empty round
    slot(NN'(16'h8888), 2, 1'b0, '0, 1'b0);
    // R3: input 0 silent, others loaded
    slot(NN'(16'hF6A0), 0, 1'b0, '0, 1'b0);
    for (int t = 0; t < 40; t++) begin
      logic [NN-1:0] r;
      r = NN'($urandom);
      if (t % 3 == 0) r = r & NN'($urandom);
      if (t % 3 == 1) r = r | NN'($urandom);
      slot(r, 0, 1'b0, '0, (t % 5) == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule